// File: doc/BRIEF.md
# Formatted Serial Transmit Port

This block sends the 13-bit two's complement result of a converter as a 16-bit serial frame. An external transmit latch presents the word, and a sequencer pulses an update strobe whenever that latch takes a new value. A level-sensitive enable opens a transfer and a slower data clock paces the bits, most significant first. Both are sampled on the system clock. While the enable is low, the output-enable for the three-state pad buffer is low.

A format select picks where the three surplus sign bits go: either ahead of the magnitude or behind it. The frame is captured into a rotating register at the moment the first bit is launched. If the enable stays high past the sixteenth bit, the same frame starts again. The capture must not fall in the same cycle as a latch update. When it does, a collision flag is raised for that frame. A data-valid flag records whether the converter was active when the frame was captured. While the converter is inactive, the latch keeps its last value and the frame carries it.

The controller has three states:

- **IDLE**: the pad is released.
- **ARMED**: the enable is high and the block waits for the first data-clock rise.
- **SHIFT**: a frame is loaded and being sent.

It has these transitions:

- **open_armed**: IDLE to ARMED, when the enable is high and the data clock is low.
- **open_load**: IDLE to SHIFT, when the enable is high and the data clock is high.
- **first_edge**: ARMED to SHIFT, on a data-clock rise.
- **step**: SHIFT to SHIFT, on a data-clock rise, which rotates the frame.
- **release**: any state to IDLE, when the enable is low.

Top module: `sertx_top`

## Requirements
- R1: One cycle after the enable is sampled low, `tx_oe` is 0. Whenever `tx_oe` is 0, `tx_sd` is 0.
- R2: One cycle after the enable is sampled high, `tx_oe` is 1.
- R3: If the data clock is low when the enable opens a transfer, `tx_sd` stays 0 until the first data-clock rise. That rise launches bit one.
- R4: If the data clock is high when the enable opens a transfer, bit one appears one cycle later. The next data-clock rise launches bit two.
- R5: Each later bit appears one cycle after a data-clock rise. Between rises `tx_sd` holds its value.
- R6: With `fmt_sel`=0 at capture, the sending order is four copies of word bit 12 (the sign), then word bits 11 down to 0.
- R7: With `fmt_sel`=1 at capture, the sending order is word bit 12, then word bits 11 down to 0, then three copies of word bit 12.
- R8: After sixteen bits, further data-clock rises send the same frame again from bit one.
- R9: The frame capture happens in the cycle that launches bit one. `collide` is set if `lat_upd` is high in that cycle and cleared otherwise. It holds between captures.
- R10: Changes of `lat_word` or `fmt_sel` while the enable stays high do not alter the frame. A new capture needs the enable to go low and then high again.
- R11: `data_ok` takes the value of `adc_on` at each capture and holds between captures.
- R12: After reset, `tx_sd`, `tx_oe`, `collide` and `data_ok` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lat_word | input | 13 | Transmit latch contents, two's complement |
| lat_upd | input | 1 | Latch update strobe from the sequencer |
| tx_en | input | 1 | Transmit enable (level) |
| tx_dclk | input | 1 | Transmit data clock, sampled on clk |
| fmt_sel | input | 1 | 0: sign extension in front, 1: sign padding at the end |
| adc_on | input | 1 | Converter active |
| tx_sd | output | 1 | Serial data toward the pad |
| tx_oe | output | 1 | Output-enable for the three-state pad |
| collide | output | 1 | Last capture coincided with a latch update |
| data_ok | output | 1 | Converter was active at the last capture |

## Verification
A controller stuck in ARMED or SHIFT after the enable falls shows up as `tx_oe` still high one cycle later. A controller that skips ARMED when the data clock is low puts a data bit on `tx_sd` one cycle after the enable rises, when it should read 0. A rotation that is off by one, or a frame built with the wrong sign placement, gives a wrong `tx_sd` value at the first bit that differs from the expected order. In a frame built to expose it, that bit is within the first sixteen data-clock rises. A capture taken in the wrong cycle shows as a wrong `collide` or `data_ok` level on the cycle right after the capture.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_SHIFT = 2'd2
    } tx_state_t;

endpackage

// File: rtl/sertx_edge.sv
module sertx_edge #(
    parameter int N = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] sig,
    output logic [N-1:0] rise
);
    logic [N-1:0] prev_q;

    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q[i] <= 1'b0;
            else        prev_q[i] <= sig[i];
        end
        assign rise[i] = sig[i] & ~prev_q[i];
    end
endmodule

// File: rtl/sertx_frame.sv
module sertx_frame #(
    parameter int MAG_W   = 12,
    parameter int FRAME_W = 16
) (
    input  logic [MAG_W:0]     word,
    input  logic               fmt,
    output logic [FRAME_W-1:0] frame
);
    localparam int EXT_F = FRAME_W - MAG_W;
    localparam int PAD_B = FRAME_W - MAG_W - 1;

    logic               sgn;
    logic [MAG_W-1:0]   mag;
    logic [FRAME_W-1:0] lead_ext;
    logic [FRAME_W-1:0] tail_pad;

    assign sgn      = word[MAG_W];
    assign mag      = word[MAG_W-1:0];
    assign lead_ext = {{EXT_F{sgn}}, mag};
    assign tail_pad = {sgn, mag, {PAD_B{sgn}}};
    assign frame    = fmt ? tail_pad : lead_ext;
endmodule

// File: rtl/sertx_fsm.sv
module sertx_fsm
    import sertx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic dclk,
    input  logic dclk_rise,
    output logic load,
    output logic rot,
    output logic oe,
    output logic armed
);
    tx_state_t st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        load = 1'b0;
        rot  = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (en) begin
                    if (dclk) begin
                        load = 1'b1;
                        st_d = ST_SHIFT;
                    end else begin
                        st_d = ST_ARMED;
                    end
                end
            end
            ST_ARMED: begin
                if (!en) begin
                    st_d = ST_IDLE;
                end else if (dclk_rise) begin
                    load = 1'b1;
                    st_d = ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                if (!en)            st_d = ST_IDLE;
                else if (dclk_rise) rot  = 1'b1;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_comb begin
        oe    = (st_q != ST_IDLE);
        armed = (st_q == ST_ARMED);
    end
endmodule

// File: rtl/sertx_shreg.sv
module sertx_shreg #(
    parameter int FRAME_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               rot,
    input  logic [FRAME_W-1:0] frame,
    output logic               msb
);
    logic [FRAME_W-1:0] sr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    sr_q <= '0;
        else if (load) sr_q <= frame;
        else if (rot)  sr_q <= {sr_q[FRAME_W-2:0], sr_q[FRAME_W-1]};
    end

    assign msb = sr_q[FRAME_W-1];
endmodule

// File: rtl/sertx_top.sv
module sertx_top #(
    parameter int MAG_W   = 12,
    parameter int FRAME_W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [MAG_W:0] lat_word,
    input  logic           lat_upd,
    input  logic           tx_en,
    input  logic           tx_dclk,
    input  logic           fmt_sel,
    input  logic           adc_on,
    output logic           tx_sd,
    output logic           tx_oe,
    output logic           collide,
    output logic           data_ok
);
    logic               dclk_rise;
    logic               load_pulse;
    logic               rot_pulse;
    logic               armed;
    logic               sr_msb;
    logic [FRAME_W-1:0] frame;
    logic               collide_q;
    logic               ok_q;

    sertx_edge #(.N(1)) i_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .sig  (tx_dclk),
        .rise (dclk_rise)
    );

    sertx_fsm i_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (tx_en),
        .dclk     (tx_dclk),
        .dclk_rise(dclk_rise),
        .load     (load_pulse),
        .rot      (rot_pulse),
        .oe       (tx_oe),
        .armed    (armed)
    );

    sertx_frame #(.MAG_W(MAG_W), .FRAME_W(FRAME_W)) i_frame (
        .word (lat_word),
        .fmt  (fmt_sel),
        .frame(frame)
    );

    sertx_shreg #(.FRAME_W(FRAME_W)) i_shreg (
        .clk  (clk),
        .rst_n(rst_n),
        .load (load_pulse),
        .rot  (rot_pulse),
        .frame(frame),
        .msb  (sr_msb)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            collide_q <= 1'b0;
            ok_q      <= 1'b0;
        end else if (load_pulse) begin
            collide_q <= lat_upd;
            ok_q      <= adc_on;
        end
    end

    assign tx_sd   = tx_oe & ~armed & sr_msb;
    assign collide = collide_q;
    assign data_ok = ok_q;
endmodule

// File: rtl/sertx_chk.sv
module sertx_chk (
    input logic clk,
    input logic rst_n,
    input logic tx_en,
    input logic tx_dclk,
    input logic lat_upd,
    input logic adc_on,
    input logic tx_sd,
    input logic tx_oe,
    input logic collide,
    input logic data_ok,
    input logic load,
    input logic armed
);
    logic dclk_prev;
    logic dclk_up;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dclk_prev <= 1'b0;
        else        dclk_prev <= tx_dclk;
    end
    assign dclk_up = tx_dclk & ~dclk_prev;

    p_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> !tx_oe);
    p_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_oe |-> !tx_sd);
    p_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_en |=> tx_oe);
    p_armed_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> !tx_sd);
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_oe && tx_en && !dclk_up) |=> $stable(tx_sd));
    p_collide_r9: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (collide == $past(lat_upd)));
    p_collide_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(collide));
    p_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (data_ok == $past(adc_on)));
    p_valid_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(data_ok));
endmodule

bind sertx_top sertx_chk i_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .tx_en  (tx_en),
    .tx_dclk(tx_dclk),
    .lat_upd(lat_upd),
    .adc_on (adc_on),
    .tx_sd  (tx_sd),
    .tx_oe  (tx_oe),
    .collide(collide),
    .data_ok(data_ok),
    .load   (load_pulse),
    .armed  (armed)
);

// File: tb/test_sertx_top.sv
module test_sertx_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] lat_word = '0;
    logic        lat_upd = 1'b0;
    logic        tx_en = 1'b0;
    logic        tx_dclk = 1'b0;
    logic        fmt_sel = 1'b0;
    logic        adc_on = 1'b0;
    logic        tx_sd, tx_oe, collide, data_ok;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    sertx_top i_sertx_top (
        .clk(clk), .rst_n(rst_n), .lat_word(lat_word), .lat_upd(lat_upd),
        .tx_en(tx_en), .tx_dclk(tx_dclk), .fmt_sel(fmt_sel), .adc_on(adc_on),
        .tx_sd(tx_sd), .tx_oe(tx_oe), .collide(collide), .data_ok(data_ok)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // k-th bit sent (k=0 first) for a word and format
    function automatic logic sent_bit(input logic [12:0] w, input logic f, input int k);
        if (!f) return (k < 4) ? w[12] : w[15-k];
        else    return (k == 0 || k > 12) ? w[12] : w[12-k];
    endfunction

    task automatic close_xfer();
        tx_en = 1'b0; tx_dclk = 1'b0;
        step();
        chk("R1 oe", {15'd0, tx_oe}, 16'd0);
        chk("R1 sd", {15'd0, tx_sd}, 16'd0);
    endtask

    task automatic t_reset();
        chk("R12 outs", {12'd0, tx_sd, tx_oe, collide, data_ok}, 16'd0);
    endtask

    // first bit launched by the data clock, then all sixteen bits
    task automatic t_clock_low(input logic [12:0] w, input logic f, input string rq);
        lat_word = w; fmt_sel = f; tx_dclk = 1'b0; tx_en = 1'b1; adc_on = 1'b1;
        step();
        chk("R2 oe", {15'd0, tx_oe}, 16'd1);
        chk("R3 armed sd", {15'd0, tx_sd}, 16'd0);
        step();
        chk("R3 still armed", {15'd0, tx_sd}, 16'd0);
        for (int k = 0; k < 16; k++) begin
            tx_dclk = 1'b1;
            step();
            chk(rq, {15'd0, tx_sd}, {15'd0, sent_bit(w, f, k)});
            tx_dclk = 1'b0;
            step();
            chk("R5 hold", {15'd0, tx_sd}, {15'd0, sent_bit(w, f, k)});
        end
        close_xfer();
    endtask

    // first bit launched by the enable; recirculation; mid-transfer changes ignored
    task automatic t_clock_high(input logic [12:0] w, input logic f);
        lat_word = w; fmt_sel = f; tx_dclk = 1'b1; tx_en = 1'b1;
        step();
        chk("R4 bit one", {15'd0, tx_sd}, {15'd0, sent_bit(w, f, 0)});
        tx_dclk = 1'b0;
        step();
        chk("R4 held", {15'd0, tx_sd}, {15'd0, sent_bit(w, f, 0)});
        lat_word = ~w; fmt_sel = ~f;
        for (int k = 1; k < 40; k++) begin
            tx_dclk = 1'b1;
            step();
            if (k == 1)
                chk("R4 bit two", {15'd0, tx_sd}, {15'd0, sent_bit(w, f, 1)});
            else if (k >= 16)
                chk("R8 recirc", {15'd0, tx_sd}, {15'd0, sent_bit(w, f, k % 16)});
            else
                chk("R10 frozen", {15'd0, tx_sd}, {15'd0, sent_bit(w, f, k)});
            tx_dclk = 1'b0;
            step();
        end
        close_xfer();
    endtask

    task automatic t_collision();
        lat_word = 13'h1ABC; fmt_sel = 1'b1; adc_on = 1'b0;
        lat_upd = 1'b1; tx_dclk = 1'b1; tx_en = 1'b1;
        step();
        lat_upd = 1'b0;
        chk("R9 set", {15'd0, collide}, 16'd1);
        chk("R11 off", {15'd0, data_ok}, 16'd0);
        tx_dclk = 1'b0; adc_on = 1'b1;
        step();
        lat_upd = 1'b1;
        step();
        lat_upd = 1'b0;
        chk("R9 held", {15'd0, collide}, 16'd1);
        chk("R11 held", {15'd0, data_ok}, 16'd0);
        close_xfer();
        lat_word = 13'h0123; tx_en = 1'b1;
        step();
        tx_dclk = 1'b1;
        step();
        chk("R9 clear", {15'd0, collide}, 16'd0);
        chk("R11 on", {15'd0, data_ok}, 16'd1);
        chk("R10 reload", {15'd0, tx_sd}, {15'd0, sent_bit(13'h0123, 1'b1, 0)});
        close_xfer();
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        step();
        t_reset();
        t_clock_low(13'h1A5C, 1'b0, "R6 fmt0");
        t_clock_low(13'h0B37, 1'b0, "R6 fmt0 pos");
        t_clock_low(13'h1A5C, 1'b1, "R7 fmt1");
        t_clock_low(13'h0B37, 1'b1, "R7 fmt1 pos");
        t_clock_high(13'h1369, 1'b0);
        t_clock_high(13'h04C6, 1'b1);
        t_collision();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule